// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides when a new thread block may be placed on a multiprocessor. It tracks three limited resources: free register-file entries, free shared-memory bytes and free warp contexts. It also tracks a fixed set of block slots. A launch request carries three values: the block's warp count, its registers per warp and its shared-memory bytes. The request is granted only when every resource can hold the whole block at once. A block is never admitted in part, and nothing is ever evicted to make room.

After admission, the block's warps stay marked resident. Its registers, bytes, warp contexts and slot stay reserved until every one of its warps has sent an exit pulse. No warp state is ever saved out or brought back. When the last warp exits, the block's resources are released in the following cycle. A request that is waiting can use them from the cycle after that. Each grant reports the block slot chosen and the warp contexts assigned to the block.

Top module: `adm_ctrl`

## Requirements
- R1: After reset, no warp is resident, and the full capacity is free. A request for all 16 warps at 64 registers each with 8192 bytes shows ready high.
- R2: ready is low when the request's warp count times its registers per warp exceeds the free register count. A product equal to the free count is accepted.
- R3: ready is low when the requested shared-memory bytes exceed the free bytes. A request equal to the free bytes is accepted.
- R4: ready is low when no block slot is idle, or when fewer warp contexts are free than the request's warp count.
- R5: On accept (valid and ready in the same cycle), grant_slot gives the lowest-numbered idle slot. grant_warps has exactly req_warps bits set, on the lowest-numbered free warp contexts. From the next cycle those bits are set in resident_warps.
- R6: resident_warps bits of a block stay set, and its resources stay reserved, while any warp of that block has not exited.
- R7: If the last live warp of a block pulses warp_exit in cycle t, then from cycle t+2 the block's resident_warps bits are clear. Its registers, bytes, warp contexts and slot are also usable for admission from cycle t+2.
- R8: A warp_exit pulse on a warp that is not resident, or on a warp that has already exited, has no effect.
- R9: A request with a warp count of 0, or one above the number of warp contexts, keeps ready low.
- R10: While a block is being released in cycle t+1, admission in that same cycle is judged on the resource amounts before the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Launch request present |
| req_warps | input | 5 | Warps in the requested block |
| req_regs_per_warp | input | 8 | Registers needed by each warp |
| req_smem | input | 14 | Shared-memory bytes needed by the block |
| req_ready | output | 1 | All resources can hold the block; accept when valid is also high |
| grant_slot | output | 2 | Block slot given on accept |
| grant_warps | output | 16 | Warp contexts given on accept |
| warp_exit | input | 16 | One-cycle exit pulse per warp context |
| resident_warps | output | 16 | Warp contexts currently held by admitted blocks |

## Verification
A sequence of requests fills the resources one at a time. It tries sizes that fit, sizes that miss on registers only, sizes that miss on shared memory only, sizes that miss on warp contexts only, sizes that miss on slots only, and warp counts that are not legal. Each of these patterns shows which comparison gates ready. Requests exactly at the register limit and exactly at the byte limit separate a correct "fits" test from an off-by-one test. Partial exits, repeated exits and exits of idle warps, followed by a final exit, tell early release and double counting apart from correct release. A request held pending across the final exit pins the two-cycle release timing.

// File: rtl/adm_pkg.sv
`timescale 1ns/1ps
package adm_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_LIVE  = 2'd1,
    SLOT_DRAIN = 2'd2
  } slot_state_e;
endpackage

// File: rtl/adm_rst_sync.sv
`timescale 1ns/1ps
module adm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/adm_pool.sv
`timescale 1ns/1ps
module adm_pool #(
  parameter int TOTAL = 1024,
  parameter int AW    = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_en,
  input  logic [AW-1:0] take_amt,
  input  logic          give_en,
  input  logic [AW-1:0] give_amt,
  output logic [AW-1:0] free_o
);
  logic [AW-1:0] free_q, free_n;
  logic          free_en;

  always_comb begin
    free_en = take_en | give_en;
    free_n  = free_q;
    if (take_en) free_n = free_n - take_amt;
    if (give_en) free_n = free_n + give_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       free_q <= AW'(TOTAL);
    else if (free_en) free_q <= free_n;
  end

  assign free_o = free_q;

  AST_TAKE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |-> (take_amt <= free_q)); // R2
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= AW'(TOTAL)); // R7
endmodule

// File: rtl/adm_warp_alloc.sv
`timescale 1ns/1ps
module adm_warp_alloc #(
  parameter int NUM_WARPS = 16,
  parameter int WCNT_W    = $clog2(NUM_WARPS + 1)
) (
  input  logic [NUM_WARPS-1:0] busy,
  input  logic [WCNT_W-1:0]    want,
  output logic [NUM_WARPS-1:0] pick,
  output logic                 enough
);
  logic [WCNT_W-1:0] taken;

  always_comb begin
    pick  = '0;
    taken = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (!busy[i] && (taken < want)) begin
        pick[i] = 1'b1;
        taken   = taken + 1'b1;
      end
    end
    enough = (taken == want);
  end
endmodule

// File: rtl/adm_slot_table.sv
`timescale 1ns/1ps
module adm_slot_table
  import adm_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_WARPS = 16,
  parameter int WCNT_W    = 5,
  parameter int SLOT_W    = 2,
  parameter int REG_W     = 11,
  parameter int SMEM_W    = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [NUM_WARPS-1:0] alloc_mask,
  input  logic [WCNT_W-1:0]    alloc_count,
  input  logic [REG_W-1:0]     alloc_regs,
  input  logic [SMEM_W-1:0]    alloc_smem,
  input  logic [NUM_WARPS-1:0] warp_exit,
  output logic                 slot_avail,
  output logic [SLOT_W-1:0]    slot_idx,
  output logic [NUM_WARPS-1:0] resident,
  output logic                 rel_any,
  output logic [REG_W-1:0]     rel_regs,
  output logic [SMEM_W-1:0]    rel_smem
);
  slot_state_e          st_q    [NUM_SLOTS];
  slot_state_e          st_n    [NUM_SLOTS];
  logic [WCNT_W-1:0]    live_q  [NUM_SLOTS];
  logic [WCNT_W-1:0]    live_n  [NUM_SLOTS];
  logic [NUM_WARPS-1:0] owner_q [NUM_SLOTS];
  logic [NUM_WARPS-1:0] owner_n [NUM_SLOTS];
  logic [REG_W-1:0]     regs_q  [NUM_SLOTS];
  logic [REG_W-1:0]     regs_n  [NUM_SLOTS];
  logic [SMEM_W-1:0]    smem_q  [NUM_SLOTS];
  logic [SMEM_W-1:0]    smem_n  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_en;
  logic [NUM_WARPS-1:0] exited_q, exited_n, eff_exit, drain_warps;
  logic [WCNT_W-1:0]    dec;

  // lowest idle slot wins
  always_comb begin
    slot_avail = 1'b0;
    slot_idx   = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (st_q[s] == SLOT_IDLE) begin
        slot_avail = 1'b1;
        slot_idx   = SLOT_W'(s);
      end
    end
  end

  // residency and release totals
  always_comb begin
    resident    = '0;
    drain_warps = '0;
    rel_any     = 1'b0;
    rel_regs    = '0;
    rel_smem    = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      resident = resident | owner_q[s];
      if (st_q[s] == SLOT_DRAIN) begin
        drain_warps = drain_warps | owner_q[s];
        rel_any     = 1'b1;
        rel_regs    = rel_regs + regs_q[s];
        rel_smem    = rel_smem + smem_q[s];
      end
    end
  end

  // only first exit of a resident warp counts
  assign eff_exit = warp_exit & resident & ~exited_q;
  assign exited_n = (exited_q | eff_exit) & ~drain_warps;

  always_comb begin
    dec = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      st_n[s]    = st_q[s];
      live_n[s]  = live_q[s];
      owner_n[s] = owner_q[s];
      regs_n[s]  = regs_q[s];
      smem_n[s]  = smem_q[s];
      slot_en[s] = 1'b0;
      case (st_q[s])
        SLOT_IDLE: begin
          if (alloc_en && (slot_idx == SLOT_W'(s))) begin
            slot_en[s] = 1'b1;
            st_n[s]    = SLOT_LIVE;
            live_n[s]  = alloc_count;
            owner_n[s] = alloc_mask;
            regs_n[s]  = alloc_regs;
            smem_n[s]  = alloc_smem;
          end
        end
        SLOT_LIVE: begin
          slot_en[s] = 1'b1;
          dec        = WCNT_W'($countones(eff_exit & owner_q[s]));
          live_n[s]  = live_q[s] - dec;
          if (live_n[s] == '0) st_n[s] = SLOT_DRAIN;
        end
        SLOT_DRAIN: begin
          slot_en[s] = 1'b1;
          st_n[s]    = SLOT_IDLE;
          owner_n[s] = '0;
          regs_n[s]  = '0;
          smem_n[s]  = '0;
        end
        default: begin
          slot_en[s] = 1'b1;
          st_n[s]    = SLOT_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exited_q <= '0;
    else        exited_q <= exited_n;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]    <= SLOT_IDLE;
        live_q[g]  <= '0;
        owner_q[g] <= '0;
        regs_q[g]  <= '0;
        smem_q[g]  <= '0;
      end else if (slot_en[g]) begin
        st_q[g]    <= st_n[g];
        live_q[g]  <= live_n[g];
        owner_q[g] <= owner_n[g];
        regs_q[g]  <= regs_n[g];
        smem_q[g]  <= smem_n[g];
      end
    end
  end

  AST_RESIDENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_any |=> (($past(resident) & ~resident) == '0)); // R6
  AST_ALLOC_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> ((alloc_mask & resident) == '0)); // R5
endmodule

// File: rtl/adm_ctrl.sv
`timescale 1ns/1ps
module adm_ctrl
  import adm_pkg::*;
#(
  parameter int NUM_WARPS  = 16,
  parameter int NUM_SLOTS  = 4,
  parameter int REG_TOTAL  = 1024,
  parameter int RPW_W      = 8,
  parameter int SMEM_TOTAL = 8192,
  localparam int WCNT_W = $clog2(NUM_WARPS + 1),
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SMEM_W = $clog2(SMEM_TOTAL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [WCNT_W-1:0]    req_warps,
  input  logic [RPW_W-1:0]     req_regs_per_warp,
  input  logic [SMEM_W-1:0]    req_smem,
  output logic                 req_ready,
  output logic [SLOT_W-1:0]    grant_slot,
  output logic [NUM_WARPS-1:0] grant_warps,
  input  logic [NUM_WARPS-1:0] warp_exit,
  output logic [NUM_WARPS-1:0] resident_warps
);
  localparam int REG_W  = $clog2(REG_TOTAL + 1);
  localparam int NEED_W = WCNT_W + RPW_W;
  localparam int CMP_W  = (NEED_W > REG_W) ? NEED_W : REG_W;

  logic                 rst_sync_n;
  logic [REG_W-1:0]     reg_free, rel_regs;
  logic [SMEM_W-1:0]    smem_free, rel_smem;
  logic                 rel_any, slot_avail, warp_enough, count_ok;
  logic                 fit_regs, fit_smem, accept;
  logic [NEED_W-1:0]    need_regs;
  logic [SLOT_W-1:0]    slot_idx;
  logic [NUM_WARPS-1:0] pick, resident;

  adm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign need_regs = NEED_W'(req_warps) * NEED_W'(req_regs_per_warp);
  assign count_ok  = (req_warps != '0) && (req_warps <= WCNT_W'(NUM_WARPS));
  assign fit_regs  = CMP_W'(need_regs) <= CMP_W'(reg_free);
  assign fit_smem  = req_smem <= smem_free;
  assign req_ready = count_ok & fit_regs & fit_smem & slot_avail & warp_enough;
  assign accept    = req_valid & req_ready;

  adm_pool #(.TOTAL(REG_TOTAL), .AW(REG_W)) u_reg_pool (
    .clk(clk), .rst_n(rst_sync_n),
    .take_en(accept), .take_amt(need_regs[REG_W-1:0]),
    .give_en(rel_any), .give_amt(rel_regs),
    .free_o(reg_free)
  );

  adm_pool #(.TOTAL(SMEM_TOTAL), .AW(SMEM_W)) u_smem_pool (
    .clk(clk), .rst_n(rst_sync_n),
    .take_en(accept), .take_amt(req_smem),
    .give_en(rel_any), .give_amt(rel_smem),
    .free_o(smem_free)
  );

  adm_warp_alloc #(.NUM_WARPS(NUM_WARPS), .WCNT_W(WCNT_W)) u_alloc (
    .busy(resident), .want(req_warps), .pick(pick), .enough(warp_enough)
  );

  adm_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_WARPS(NUM_WARPS), .WCNT_W(WCNT_W),
    .SLOT_W(SLOT_W), .REG_W(REG_W), .SMEM_W(SMEM_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_sync_n),
    .alloc_en(accept), .alloc_mask(pick), .alloc_count(req_warps),
    .alloc_regs(need_regs[REG_W-1:0]), .alloc_smem(req_smem),
    .warp_exit(warp_exit),
    .slot_avail(slot_avail), .slot_idx(slot_idx), .resident(resident),
    .rel_any(rel_any), .rel_regs(rel_regs), .rel_smem(rel_smem)
  );

  assign grant_slot     = slot_idx;
  assign grant_warps    = pick;
  assign resident_warps = resident;

  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |-> ($countones(grant_warps) == int'(req_warps))); // R5
  AST_GRANT_LANDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> ((($past(grant_warps)) & ~resident_warps) == '0)); // R5
endmodule

// File: tb/sim_adm_ctrl.sv
`timescale 1ns/1ps
module sim_adm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_warps = '0;
  logic [7:0]  req_regs_per_warp = '0;
  logic [13:0] req_smem = '0;
  logic        req_ready;
  logic [1:0]  grant_slot;
  logic [15:0] grant_warps;
  logic [15:0] warp_exit = '0;
  logic [15:0] resident_warps;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_warps(req_warps),
    .req_regs_per_warp(req_regs_per_warp), .req_smem(req_smem),
    .req_ready(req_ready), .grant_slot(grant_slot), .grant_warps(grant_warps),
    .warp_exit(warp_exit), .resident_warps(resident_warps)
  );

  // warps, regs/warp, smem, ready, slot, grant mask, resident after
  localparam logic [61:0] VEC [0:9] = '{
    {5'd4,  8'd64,  14'd1024, 1'b1, 2'd0, 16'h000F, 16'h000F},
    {5'd4,  8'd128, 14'd1024, 1'b1, 2'd1, 16'h00F0, 16'h00FF},
    {5'd2,  8'd200, 14'd0,    1'b0, 2'd0, 16'h0000, 16'h00FF},
    {5'd1,  8'd16,  14'd7000, 1'b0, 2'd0, 16'h0000, 16'h00FF},
    {5'd17, 8'd0,   14'd0,    1'b0, 2'd0, 16'h0000, 16'h00FF},
    {5'd2,  8'd64,  14'd6144, 1'b1, 2'd2, 16'h0300, 16'h03FF},
    {5'd7,  8'd0,   14'd0,    1'b0, 2'd0, 16'h0000, 16'h03FF},
    {5'd1,  8'd0,   14'd0,    1'b1, 2'd3, 16'h0400, 16'h07FF},
    {5'd1,  8'd0,   14'd0,    1'b0, 2'd0, 16'h0000, 16'h07FF},
    {5'd0,  8'd0,   14'd0,    1'b0, 2'd0, 16'h0000, 16'h07FF}
  };
  localparam string VTAG [0:9] = '{"R5", "R5", "R2", "R3", "R9",
                                   "R3", "R4", "R5", "R4", "R9"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [4:0] w, input logic [7:0] r, input logic [13:0] s);
    req_warps = w; req_regs_per_warp = r; req_smem = s; req_valid = 1'b1;
  endtask

  task automatic pulse_exit(input logic [15:0] m);
    @(negedge clk) warp_exit = m;
    @(negedge clk) warp_exit = '0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 reset resident", 32'(resident_warps), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: full capacity visible after reset
    @(negedge clk); present(5'd16, 8'd64, 14'd8192); req_valid = 1'b0;
    #1 check("R1 ready at full capacity", 32'(req_ready), 32'h1);
    check("R1 resident after reset", 32'(resident_warps), 32'h0);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      present(VEC[i][61:57], VEC[i][56:49], VEC[i][48:35]);
      #1 check({VTAG[i], " ready"}, 32'(req_ready), 32'(VEC[i][34]));
      if (VEC[i][34]) begin
        check({VTAG[i], " slot"}, 32'(grant_slot), 32'(VEC[i][33:32]));
        check({VTAG[i], " grant"}, 32'(grant_warps), 32'(VEC[i][31:16]));
      end
      @(negedge clk) req_valid = 1'b0;
      #1 check({VTAG[i], " resident"}, 32'(resident_warps), 32'(VEC[i][15:0]));
    end

    // R6: partial exits keep the block
    pulse_exit(16'h0003);
    #1 check("R6 partial exit resident", 32'(resident_warps), 32'h07FF);
    // R8: repeat exit and idle-warp exit ignored
    pulse_exit(16'h8001);
    pulse_exit(16'h0004);
    repeat (3) @(negedge clk);
    #1 check("R8 ignored exits resident", 32'(resident_warps), 32'h07FF);

    // R7 / R10: last exit with a pending request
    @(negedge clk) warp_exit = 16'h0008; present(5'd4, 8'd64, 14'd1024);
    #1 check("R10 ready in exit cycle", 32'(req_ready), 32'h0);
    @(negedge clk) warp_exit = '0;
    #1 check("R10 ready in release cycle", 32'(req_ready), 32'h0);
    check("R7 resident in release cycle", 32'(resident_warps), 32'h07FF);
    @(negedge clk);
    #1 check("R7 resident two cycles after", 32'(resident_warps), 32'h07F0);
    check("R7 ready two cycles after", 32'(req_ready), 32'h1);
    check("R5 reused slot", 32'(grant_slot), 32'h0);
    check("R5 reused warps", 32'(grant_warps), 32'h000F);
    @(negedge clk) req_valid = 1'b0;
    #1 check("R5 resident after reuse", 32'(resident_warps), 32'h07FF);

    // R2 / R3 boundaries: 128 regs and 0 bytes free once slot 3 drains
    pulse_exit(16'h0400);
    @(negedge clk);
    #1 check("R7 single-warp release", 32'(resident_warps), 32'h03FF);
    present(5'd2, 8'd65, 14'd0);
    #1 check("R2 one register short", 32'(req_ready), 32'h0);
    present(5'd2, 8'd64, 14'd1);
    #1 check("R3 one byte short", 32'(req_ready), 32'h0);
    present(5'd2, 8'd64, 14'd0);
    #1 check("R2 exact register fit", 32'(req_ready), 32'h1);
    check("R5 slot after drain", 32'(grant_slot), 32'h3);
    check("R5 warps after drain", 32'(grant_warps), 32'h0C00);
    @(negedge clk) req_valid = 1'b0;
    #1 check("R5 resident after fit", 32'(resident_warps), 32'h0FFF);

    // R1: reset in mid-run
    do_reset();
    present(5'd16, 8'd64, 14'd8192);
    #1 check("R1 ready after second reset", 32'(req_ready), 32'h1);
    check("R1 full grant", 32'(grant_warps), 32'hFFFF);
    check("R1 slot after reset", 32'(grant_slot), 32'h0);
    @(negedge clk) req_valid = 1'b0;
    #1 check("R1 resident full block", 32'(resident_warps), 32'hFFFF);
    finish_run();
  end
endmodule